// File: doc/BRIEF.md
# SD Card Data-Line Transfer Engine

This block moves whole data blocks between 32-bit word queues and the four SD card data lines. It works with a single line (lane 0 only) or with all four lanes at once. A command word starts either a write, where words taken from a transmit queue are sent to the card, or a read, where the card's serial data is packed into words for a receive queue. The byte count per block, the number of extra blocks and the lane width are captured when the command is given. Later changes on those inputs have no effect until the next command.

Every block travels in a frame. The frame holds a low start bit, the payload, a 16-bit checksum for each active lane and a high end bit. On reads the engine checks each lane's checksum. On writes it appends the checksums. It then waits for the card's three-bit acceptance token and holds off while the card pulls lane 0 low to signal it is busy. A bad block, either a checksum mismatch on a read or a rejected token on a write, ends the transfer after that block. The pad tri-state buffers, the command line and clock generation sit outside this block.

Top module: `sd_lane_engine`

## Requirements
- R1: `cmd` = 1 starts a write and `cmd` = 2 starts a read, but only while the engine is idle. Values 0 and 3 start nothing. `blk_bytes`, `blk_extra` and `wide_bus` are captured only in the cycle where the command is accepted.
- R2: With `wide_bus` = 0, only lane 0 carries frame bits, and lanes 3..1 are driven as 1 whenever `dat_oe` is high. With `wide_bus` = 1, all lanes carry data, and each 32-bit word is sent or assembled most significant nibble first, with bit 3 of the nibble on lane 3.
- R3: A frame is one start cycle (0 on every active lane), then `blk_bytes`×8/width data cycles, then 16 checksum cycles, then one end cycle of 4'hF. When the engine is not driving, `dat_out` rests at 4'hF.
- R4: Each lane has its own CRC16. It shifts right, uses the reflected constant 16'h8408, starts from zero for every block and is sent least significant bit first.
- R5: On reads, `rx_push` is high for exactly one cycle each time 32 bits have been assembled, with the word on `rx_word`. A trailing part-word is not pushed, so a block yields floor(`blk_bytes`/4) pushes.
- R6: On writes, `tx_pop` pulses once for each word loaded, ceil(`blk_bytes`/4) times per block. `dat_oe` is high from the start cycle through the end cycle and low in the cycle after.
- R7: After each written block, the card answers on lane 0 with a 0, three status bits (first received bit is the MSB) and a 1. The status 3'b010 sets `crc_good`. Any other status clears `crc_good` and ends the transfer once the card stops being busy.
- R8: After the token, `card_busy` follows lane 0 being low. The next written block's start cycle comes at least two cycles after lane 0 returns high.
- R9: A transfer carries `blk_extra`+1 blocks. `xfer_busy` rises in the cycle after the command is accepted and falls once the last block has finished.
- R10: At the end of each read block, `crc_good` shows whether every active lane's checksum matched. A mismatch ends the transfer after that block.
- R11: During and after reset, `tx_pop`, `rx_push`, `dat_oe`, `card_busy`, `xfer_busy` and `crc_good` are all low.
- R12: Block sizes that are not a multiple of four bytes (for example 5, 7, 13 or 19) are framed with the exact cycle count from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-side clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Head word consumed this cycle |
| rx_word | output | 32 | Assembled receive word |
| rx_push | output | 1 | `rx_word` is valid this cycle |
| dat_oe | output | 1 | Drive enable for the data lanes |
| dat_out | output | 4 | Value driven on lanes 3..0 |
| dat_in | input | 4 | Value sampled on lanes 3..0 |
| blk_bytes | input | SIZE_W | Bytes per block |
| blk_extra | input | CNT_W | Number of blocks minus one |
| wide_bus | input | 1 | 1 selects four lanes, 0 selects lane 0 only |
| cmd | input | 2 | 1 write, 2 read, others no operation |
| card_busy | output | 1 | Card holds lane 0 low after a written block |
| xfer_busy | output | 1 | Transfer in progress |
| crc_good | output | 1 | Result of the most recent block |

## Verification
Reads and writes are each tried in both lane widths, with one block and with several blocks. This separates payload ordering and per-lane checksum faults from faults in block-count handling and in the inter-block gap. Block sizes of 5, 7, 13 and 19 bytes leave a part-word at the end of the frame. They show whether the cycle count follows bytes rather than words, and whether a trailing fragment is wrongly pushed or popped. A read with inverted checksums and a write answered with a rejecting token check that the good and bad outcomes are reported apart, and that the remaining blocks are abandoned. Commands of 3 and parameter changes after the command check that nothing outside the accepted command cycle steers the engine.

// File: rtl/sd_lane_engine.sv
module sd_lane_engine #(
  parameter int SIZE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       tx_word,
  output logic              tx_pop,
  output logic [31:0]       rx_word,
  output logic              rx_push,
  output logic              dat_oe,
  output logic [3:0]        dat_out,
  input  logic [3:0]        dat_in,
  input  logic [SIZE_W-1:0] blk_bytes,
  input  logic [CNT_W-1:0]  blk_extra,
  input  logic              wide_bus,
  input  logic [1:0]        cmd,
  output logic              card_busy,
  output logic              xfer_busy,
  output logic              crc_good
);
  localparam int CYC_W = SIZE_W + 3;

  typedef enum logic [3:0] {
    IDLE, W_GAP, W_START, W_DATA, W_CRC, W_END, W_TOKWAIT, W_TOKEN, W_BUSY,
    R_WAIT, R_DATA, R_CRC, R_END
  } state_t;

  state_t            st;
  logic              wide;
  logic [SIZE_W-1:0] bytes_q;
  logic [CNT_W-1:0]  left;
  logic [CYC_W-1:0]  cyc;
  logic [4:0]        pos;
  logic [3:0]        cnt;
  logic [31:0]       sh;
  logic [2:0]        tok;
  logic [15:0]       crc    [4];
  logic [15:0]       crc_nx [4];

  wire [4:0]       pos_last  = wide ? 5'd7 : 5'd31;
  wire             word_end  = (pos == pos_last);
  wire [CYC_W-1:0] cyc_total = wide ? {2'b00, bytes_q, 1'b0} : {bytes_q, 3'b000};
  wire [3:0]       tx_sym    = wide ? sh[31:28] : {3'b111, sh[31]};
  wire [3:0]       crc_in    = (st == W_DATA) ? tx_sym : dat_in;
  wire [3:0]       crc_tail  = {crc[3][0], crc[2][0], crc[1][0], crc[0][0]};
  wire             start_seen = wide ? (dat_in == 4'h0) : !dat_in[0];
  wire             residue_ok = (crc[0] == 16'h0) &&
                                (!wide || (crc[1] == 16'h0 && crc[2] == 16'h0 && crc[3] == 16'h0));
  wire             last_blk  = (left == '0);

  always_comb begin
    for (int l = 0; l < 4; l++)
      crc_nx[l] = (crc[l] >> 1) ^ ((crc_in[l] ^ crc[l][0]) ? 16'h8408 : 16'h0000);
  end

  always_comb begin
    case (st)
      W_START: dat_out = wide ? 4'h0 : 4'hE;
      W_DATA:  dat_out = tx_sym;
      W_CRC:   dat_out = wide ? crc_tail : {3'b111, crc_tail[0]};
      default: dat_out = 4'hF;
    endcase
  end

  assign dat_oe    = (st == W_START) || (st == W_DATA) || (st == W_CRC) || (st == W_END);
  assign tx_pop    = (st == W_START) || (st == W_DATA && word_end && cyc != 1);
  assign card_busy = (st == W_BUSY) && !dat_in[0];
  assign xfer_busy = (st != IDLE);
  assign rx_word   = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; wide <= 1'b0; bytes_q <= '0; left <= '0; cyc <= '0;
      pos <= '0; cnt <= '0; sh <= '0; tok <= '0; rx_push <= 1'b0; crc_good <= 1'b0;
      for (int l = 0; l < 4; l++) crc[l] <= '0;
    end else begin
      rx_push <= 1'b0;
      case (st)
        IDLE: if (cmd == 2'd1 || cmd == 2'd2) begin
          bytes_q <= blk_bytes; left <= blk_extra; wide <= wide_bus; cnt <= '0;
          st <= (cmd == 2'd1) ? W_GAP : R_WAIT;
        end
        W_GAP: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd1) begin cnt <= '0; st <= W_START; end
        end
        W_START: begin
          sh <= tx_word; cyc <= cyc_total; pos <= '0; st <= W_DATA;
          for (int l = 0; l < 4; l++) crc[l] <= '0;
        end
        W_DATA: begin
          for (int l = 0; l < 4; l++) crc[l] <= crc_nx[l];
          if (word_end) begin sh <= tx_word; pos <= '0; end
          else begin sh <= wide ? {sh[27:0], 4'h0} : {sh[30:0], 1'b0}; pos <= pos + 5'd1; end
          cyc <= cyc - 1'b1;
          if (cyc == 1) begin cnt <= '0; st <= W_CRC; end
        end
        W_CRC: begin
          for (int l = 0; l < 4; l++) crc[l] <= crc[l] >> 1;
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) st <= W_END;
        end
        W_END: st <= W_TOKWAIT;
        W_TOKWAIT: if (!dat_in[0]) begin cnt <= '0; st <= W_TOKEN; end
        W_TOKEN: begin
          tok <= {tok[1:0], dat_in[0]};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd2) crc_good <= ({tok[1:0], dat_in[0]} == 3'b010);
          if (cnt == 4'd3) begin cnt <= '0; st <= W_BUSY; end
        end
        W_BUSY: begin
          if (cnt != 4'd3) cnt <= cnt + 4'd1;
          if (dat_in[0] && cnt >= 4'd2) begin
            cnt <= '0;
            if (!crc_good || last_blk) st <= IDLE;
            else begin left <= left - 1'b1; st <= W_GAP; end
          end
        end
        R_WAIT: if (start_seen) begin
          cyc <= cyc_total; pos <= '0; st <= R_DATA;
          for (int l = 0; l < 4; l++) crc[l] <= '0;
        end
        R_DATA: begin
          for (int l = 0; l < 4; l++) crc[l] <= crc_nx[l];
          sh <= wide ? {sh[27:0], dat_in} : {sh[30:0], dat_in[0]};
          rx_push <= word_end;
          pos <= word_end ? 5'd0 : pos + 5'd1;
          cyc <= cyc - 1'b1;
          if (cyc == 1) begin cnt <= '0; st <= R_CRC; end
        end
        R_CRC: begin
          for (int l = 0; l < 4; l++) crc[l] <= crc_nx[l];
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) st <= R_END;
        end
        R_END: begin
          crc_good <= residue_ok;
          if (!residue_ok || last_blk) st <= IDLE;
          else begin left <= left - 1'b1; st <= R_WAIT; end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_push_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);
  assert_pop_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> dat_oe);
  assert_frame_open_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_oe) |-> (dat_out[0] == 1'b0));
  assert_frame_close_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dat_oe) |-> ($past(dat_out) == 4'hF));
  assert_narrow_lanes_R2: assert property (@(posedge clk) disable iff (rst)
    (dat_oe && !wide) |-> (dat_out[3:1] == 3'b111));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !xfer_busy |-> (!dat_oe && !tx_pop && !rx_push && !card_busy));
  assert_busy_in_xfer_R8: assert property (@(posedge clk) disable iff (rst)
    card_busy |-> xfer_busy);
endmodule

// File: tb/sd_lane_engine_test.sv
module sd_lane_engine_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] tx_word;
  logic        tx_pop;
  logic [31:0] rx_word;
  logic        rx_push;
  logic        dat_oe;
  logic [3:0]  dat_out;
  logic [3:0]  dat_in;
  logic [11:0] blk_bytes;
  logic [7:0]  blk_extra;
  logic        wide_bus;
  logic [1:0]  cmd;
  logic        card_busy, xfer_busy, crc_good;

  int n_checks = 0, n_fail = 0;
  int tx_idx = 0;
  logic [31:0] exp_rx [512];
  int rx_wr = 0, rx_rd = 0, rd_base = 1000;
  bit done = 0;

  always #4 clk = ~clk;

  sd_lane_engine uut (
    .clk(clk), .rst(rst), .tx_word(tx_word), .tx_pop(tx_pop), .rx_word(rx_word),
    .rx_push(rx_push), .dat_oe(dat_oe), .dat_out(dat_out), .dat_in(dat_in),
    .blk_bytes(blk_bytes), .blk_extra(blk_extra), .wide_bus(wide_bus), .cmd(cmd),
    .card_busy(card_busy), .xfer_busy(xfer_busy), .crc_good(crc_good)
  );

  function automatic logic [31:0] pat(input int k);
    logic [31:0] kk;
    kk = k;
    return ((kk + 32'd1) * 32'h9E3779B9) ^ {kk[7:0], 24'h5A3C1F};
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return (c >> 1) ^ ((b ^ c[0]) ? 16'h8408 : 16'h0000);
  endfunction

  assign tx_word = pat(tx_idx);
  always @(posedge clk) if (tx_pop) tx_idx <= tx_idx + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rx_push) begin
    check(rx_word == exp_rx[rx_rd], "R5", "pushed word", rx_word, exp_rx[rx_rd]);
    rx_rd++;
  end

  task automatic start_cmd(input logic [1:0] c, input int size, input int cnt, input bit wide);
    @(negedge clk);
    cmd = c; blk_bytes = 12'(size); blk_extra = 8'(cnt); wide_bus = wide;
    @(negedge clk);
    cmd = 2'd0; blk_bytes = 12'hFFF; blk_extra = 8'hFF; wide_bus = !wide;
    check(xfer_busy == 1'b1, "R9", "busy after command", 32'(xfer_busy), 1);
  endtask

  task automatic run_read(input int size, input int cnt, input bit wide, input bit bad);
    int w, cycles, nw;
    logic [15:0] cr [4];
    logic [31:0] wd;
    logic [3:0] sym;
    int shf;
    w = wide ? 4 : 1; cycles = size * 8 / w; nw = (size + 3) / 4;
    start_cmd(2'd2, size, cnt, wide);
    for (int b = 0; b <= cnt; b++) begin
      repeat (2) begin @(negedge clk); dat_in = 4'hF; end
      for (int k = 0; k < size / 4; k++) begin exp_rx[rx_wr] = pat(rd_base + k); rx_wr++; end
      @(negedge clk); dat_in = wide ? 4'h0 : 4'hE;
      for (int l = 0; l < 4; l++) cr[l] = '0;
      for (int i = 0; i < cycles; i++) begin
        @(negedge clk);
        wd = pat(rd_base + (i * w) / 32);
        shf = 32 - w - ((i * w) % 32);
        sym = wide ? 4'(wd >> shf) : {3'b111, wd[shf]};
        dat_in = sym;
        for (int l = 0; l < 4; l++) cr[l] = crc_step(cr[l], sym[l]);
      end
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (wide) dat_in = {cr[3][i] ^ bad, cr[2][i] ^ bad, cr[1][i] ^ bad, cr[0][i] ^ bad};
        else      dat_in = {3'b111, cr[0][i] ^ bad};
      end
      @(negedge clk); dat_in = 4'hF;
      @(negedge clk); dat_in = 4'hF;
      check(crc_good == !bad, "R10", "read block checksum result", 32'(crc_good), 32'(!bad));
      check(xfer_busy == !(bad || b == cnt), "R9", "busy after read block",
            32'(xfer_busy), 32'(!(bad || b == cnt)));
      rd_base += nw;
      if (bad) break;
    end
    check(rx_rd == rx_wr, "R5", "push count", 32'(rx_rd), 32'(rx_wr));
  endtask

  task automatic run_write(input int size, input int cnt, input bit wide, input bit bad);
    int w, cycles, nw, wbase, n, errs;
    logic [15:0] cr [4];
    logic [31:0] wd, first_act, first_exp;
    logic [3:0] sym;
    logic [2:0] status;
    int shf;
    w = wide ? 4 : 1; cycles = size * 8 / w; nw = (size + 3) / 4;
    status = bad ? 3'b101 : 3'b010;
    wbase = tx_idx;
    dat_in = 4'hF;
    start_cmd(2'd1, size, cnt, wide);
    for (int b = 0; b <= cnt; b++) begin
      n = 0;
      while (!dat_oe && n < 60) begin n++; @(negedge clk); end
      check(n >= 2 && n < 60, "R8", "idle cycles before start", 32'(n), 2);
      check(dat_out == (wide ? 4'h0 : 4'hE), "R3", "start cycle", 32'(dat_out),
            32'(wide ? 4'h0 : 4'hE));
      for (int l = 0; l < 4; l++) cr[l] = '0;
      errs = 0; first_act = 0; first_exp = 0;
      for (int i = 0; i < cycles; i++) begin
        @(negedge clk);
        wd = pat(wbase + (i * w) / 32);
        shf = 32 - w - ((i * w) % 32);
        sym = wide ? 4'(wd >> shf) : {3'b111, wd[shf]};
        for (int l = 0; l < 4; l++) cr[l] = crc_step(cr[l], sym[l]);
        if (dat_out != sym || !dat_oe) begin
          if (errs == 0) begin first_act = 32'(dat_out); first_exp = 32'(sym); end
          errs++;
        end
      end
      check(errs == 0, "R2", "payload symbols", first_act, first_exp);
      errs = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        sym = wide ? {cr[3][i], cr[2][i], cr[1][i], cr[0][i]} : {3'b111, cr[0][i]};
        if (dat_out != sym || !dat_oe) begin
          if (errs == 0) begin first_act = 32'(dat_out); first_exp = 32'(sym); end
          errs++;
        end
      end
      check(errs == 0, "R4", "checksum symbols", first_act, first_exp);
      @(negedge clk);
      check(dat_out == 4'hF && dat_oe, "R3", "end cycle", 32'({dat_oe, dat_out}), 32'h1F);
      @(negedge clk);
      check(!dat_oe, "R6", "drive released after end", 32'(dat_oe), 0);
      check(tx_idx - wbase == nw, "R6/R12", "pops per block", 32'(tx_idx - wbase), 32'(nw));
      dat_in = 4'hE;
      for (int j = 2; j >= 0; j--) begin @(negedge clk); dat_in = {3'b111, status[j]}; end
      @(negedge clk); dat_in = 4'hF;
      @(negedge clk); dat_in = 4'hE;
      #1 check(card_busy, "R8", "card busy shown", 32'(card_busy), 1);
      repeat (3) begin @(negedge clk); dat_in = 4'hE; end
      @(negedge clk); dat_in = 4'hF;
      #1 check(!card_busy, "R8", "card busy released", 32'(card_busy), 0);
      @(negedge clk);
      check(crc_good == !bad, "R7", "token result", 32'(crc_good), 32'(!bad));
      check(xfer_busy == !(bad || b == cnt), "R9", "busy after write block",
            32'(xfer_busy), 32'(!(bad || b == cnt)));
      wbase += nw;
      if (bad) break;
    end
  endtask

  // fields: [31] write, [30] four lanes, [29] bad checksum/token, [23:16] extra blocks, [15:0] bytes
  localparam logic [31:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 5'd0, 8'd0, 16'd16},
    {1'b1, 1'b0, 1'b0, 5'd0, 8'd1, 16'd16},
    {1'b0, 1'b1, 1'b0, 5'd0, 8'd2, 16'd64},
    {1'b1, 1'b1, 1'b0, 5'd0, 8'd2, 16'd32},
    {1'b0, 1'b1, 1'b0, 5'd0, 8'd0, 16'd13},
    {1'b1, 1'b1, 1'b0, 5'd0, 8'd0, 16'd19},
    {1'b0, 1'b0, 1'b0, 5'd0, 8'd1, 16'd7},
    {1'b1, 1'b0, 1'b0, 5'd0, 8'd0, 16'd5},
    {1'b0, 1'b1, 1'b1, 5'd0, 8'd3, 16'd16},
    {1'b1, 1'b1, 1'b1, 5'd0, 8'd2, 16'd8}
  };

  initial begin
    rst = 1'b1; cmd = 2'd0; dat_in = 4'hF; blk_bytes = 12'd0; blk_extra = 8'd0; wide_bus = 1'b0;
    repeat (3) @(negedge clk);
    check({tx_pop, rx_push, dat_oe, card_busy, xfer_busy, crc_good} == 6'b0, "R11",
          "outputs in reset", 32'({tx_pop, rx_push, dat_oe, card_busy, xfer_busy, crc_good}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({tx_pop, rx_push, dat_oe, xfer_busy, crc_good} == 5'b0 && dat_out == 4'hF, "R11",
          "outputs after reset", 32'({dat_oe, xfer_busy, dat_out}), 32'hF);
    cmd = 2'd3; blk_bytes = 12'd16;
    @(negedge clk);
    cmd = 2'd0;
    check(!xfer_busy && !dat_oe, "R1", "command 3 ignored", 32'({xfer_busy, dat_oe}), 0);
    @(negedge clk);
    check(!xfer_busy, "R1", "command 0 idle", 32'(xfer_busy), 0);
    // R1 capture, R2/R3/R4 framing, R12 odd sizes are exercised across the table
    for (int v = 0; v < 10; v++) begin
      if (VEC[v][31]) run_write(int'(VEC[v][15:0]), int'(VEC[v][23:16]), VEC[v][30], VEC[v][29]);
      else            run_read (int'(VEC[v][15:0]), int'(VEC[v][23:16]), VEC[v][30], VEC[v][29]);
      repeat (3) @(negedge clk);
      check(!xfer_busy, "R9/R12", "idle after transfer", 32'(xfer_busy), 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule